// File: doc/BRIEF.md
# NAND Identification and Parameter Page Responder

This block is the device-side read-out logic that answers the identification and parameter-page requests of a NAND flash target. It watches the host's command and address cycles, which are captured on the rising edge of the write strobe, and recognises two entry sequences. The first is an identification request: opcode 90h followed by an address of 00h. The second is a parameter-page request: opcode ECh followed by an address of 00h. After either sequence is accepted, each falling edge of the read strobe advances an internal byte counter and places the selected byte on the output bus.

Identification returns five bytes. A configuration pin selects between two tables: one for the two-enable build and one for the single-enable dual-die build. The parameter page holds 256 bytes, taken from an internal constant table whose integrity CRC is stored as a constant. The page is repeated as redundant copies, and beyond the last copy the bus reads a fixed filler.

A read-out mode stays active until the next command arrives. A status request made while in identification mode is ignored; a dummy 00h command must come first. All pin inputs are assumed to be already synchronised to `clk`, and the strobes are assumed to be slow compared with it.

Top module: `nand_idpp_responder`

## Requirements
- R1: After reset, `rd_mode` is 0 (no read-out), and `io_out` is 00h. The `rd_mode` encoding is: 0 none, 1 identification, 2 parameter page, 3 status.
- R2: Command 90h followed by one address cycle of 00h sets `rd_mode` to 1. With `single_ce_cfg` low, five successive falling read-strobe edges return 01h, DCh, 90h, 95h and 54h, in that order.
- R3: With `single_ce_cfg` high, the identification sequence returns 01h, D3h, D1h, 95h and 58h.
- R4: In identification mode, every falling read-strobe edge after the fifth returns the fifth byte again.
- R5: Command ECh followed by address 00h sets `rd_mode` to 2. The page starts with 4Fh, 4Eh, 46h and 49h. Byte 64 is 01h, byte 100 is 02h and byte 101 is 23h.
- R6: Parameter bytes 256 to 511 and 512 to 767 equal bytes 0 to 255. Every byte from 768 onward reads FFh.
- R7: Address cycles and read strobes leave the current read-out mode and counter position unchanged. Any accepted command other than an ignored status request leaves the mode (for example, FFh gives `rd_mode` 0).
- R8: Command 70h is ignored in identification mode: `rd_mode` stays 1 and the byte sequence continues. After a 00h command, a 70h sets `rd_mode` to 3, and each falling read-strobe edge then returns the current `status_in`.
- R9: Holding `ce_n` high returns the byte counter to the first byte without changing `rd_mode`.
- R10: Strobes seen while `ce_n` is high have no effect. An address other than 00h after 90h or ECh leaves `rd_mode` at 0.
- R11: `io_out` changes only on a falling read-strobe edge in a read-out mode; command and address cycles leave it as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the pins |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Marks a write-strobe cycle as a command |
| ale | input | 1 | Marks a write-strobe cycle as an address |
| we_n | input | 1 | Write strobe; cycles are captured on its rising edge |
| re_n | input | 1 | Read strobe; each falling edge delivers one byte |
| io_in | input | 8 | Command or address byte from the host |
| single_ce_cfg | input | 1 | High selects the single-enable identification table |
| status_in | input | 8 | Status byte that is returned in status mode |
| io_out | output | 8 | Byte delivered by the last read strobe |
| rd_mode | output | 2 | Current read-out mode (0 none, 1 ID, 2 param, 3 status) |

## Verification
A corrupted byte counter appears on `io_out` one clock after the next falling read strobe, as a byte taken from the wrong place in the sequence. A skipped counter shifts every later byte, and a missing saturation produces a byte other than the last ID byte or the FFh filler. A wrong mode state is visible on `rd_mode` one clock after the command or address cycle that caused it. The directed reads compare every returned byte against a sequence known in advance, so a counter slip is caught at the first strobe where it happens, and the mirror check compares all 256 positions across every copy.

// File: rtl/nand_idpp_pkg.sv
// Package: shared opcodes, state type and identification tables for the
// identification / parameter-page responder.
package nand_idpp_pkg;

    localparam logic [7:0] OP_READ_ID = 8'h90;
    localparam logic [7:0] OP_PARAM   = 8'hEC;
    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_DUMMY   = 8'h00;
    localparam int         ID_LEN     = 5;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ID_ARM = 3'd1,
        ST_ID     = 3'd2,
        ST_PP_ARM = 3'd3,
        ST_PP     = 3'd4,
        ST_STAT   = 3'd5
    } rd_state_e;

    typedef enum logic [1:0] {
        RM_NONE   = 2'd0,
        RM_ID     = 2'd1,
        RM_PARAM  = 2'd2,
        RM_STATUS = 2'd3
    } rd_mode_e;

    // Identification byte for position idx; single selects the single-enable table.
    function automatic logic [7:0] id_byte(input logic single, input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h01;
            3'd1:    b = single ? 8'hD3 : 8'hDC;
            3'd2:    b = single ? 8'hD1 : 8'h90;
            3'd3:    b = 8'h95;
            default: b = single ? 8'h58 : 8'h54;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/nand_cycle_decode.sv
// Cycle decoder: turns the synchronised pin levels into one-clock strobes for a
// command cycle, an address cycle and a falling read strobe. Assumes the pins
// are already synchronised to clk and stay at each level for two or more clocks.
// Nothing is decoded while ce_n is high.
module nand_cycle_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic cle,
    input  logic ale,
    input  logic we_n,
    input  logic re_n,
    output logic cmd_stb,
    output logic addr_stb,
    output logic re_fall
);
    logic we_q;
    logic re_q;

    // Keep the previous strobe levels so that edges can be found.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q <= 1'b1;
            re_q <= 1'b1;
        end else begin
            we_q <= we_n;
            re_q <= re_n;
        end
    end

    // Classify the write-strobe rising edge and detect the read-strobe falling edge.
    always_comb begin
        cmd_stb  = ~ce_n & we_n & ~we_q & cle & ~ale;
        addr_stb = ~ce_n & we_n & ~we_q & ale & ~cle;
        re_fall  = ~ce_n & ~re_n & re_q;
    end
endmodule

// File: rtl/nand_rd_mode_ctrl.sv
// Mode controller: tracks the read-out mode from the decoded command and
// address cycles, and steps the byte counter on each read strobe.
// The identification count saturates at its last byte and the parameter count
// saturates at the end of the redundant copies. ce_n high clears the counter
// but keeps the mode.
module nand_rd_mode_ctrl
    import nand_idpp_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int PP_COPIES  = 3,
    localparam int PP_LIMIT  = PAGE_BYTES * PP_COPIES,
    localparam int CNT_W     = $clog2(PP_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             cmd_stb,
    input  logic             addr_stb,
    input  logic             re_fall,
    input  logic [7:0]       io_in,
    output rd_state_e        state,
    output logic [CNT_W-1:0] cnt
);
    rd_state_e state_nx;
    logic      status_ignored;
    logic      mode_entry;

    // A status request is dropped while identification is active.
    assign status_ignored = (state == ST_ID) && (io_in == OP_STATUS);
    assign mode_entry     = addr_stb && (io_in == 8'h00) &&
                            ((state == ST_ID_ARM) || (state == ST_PP_ARM));

    // Next-state decode from command and address cycles.
    always_comb begin
        state_nx = state;
        if (cmd_stb && !status_ignored) begin
            case (io_in)
                OP_READ_ID: state_nx = ST_ID_ARM;
                OP_PARAM:   state_nx = ST_PP_ARM;
                OP_STATUS:  state_nx = ST_STAT;
                default:    state_nx = ST_IDLE;
            endcase
        end else if (addr_stb && (state == ST_ID_ARM || state == ST_PP_ARM)) begin
            if (io_in != 8'h00)          state_nx = ST_IDLE;
            else if (state == ST_ID_ARM) state_nx = ST_ID;
            else                         state_nx = ST_PP;
        end
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Byte counter with saturation per mode.
    always_ff @(posedge clk) begin
        if (!rst_n || ce_n) begin
            cnt <= '0;
        end else if ((cmd_stb && !status_ignored) || mode_entry) begin
            cnt <= '0;
        end else if (re_fall) begin
            if (state == ST_ID) begin
                if (cnt < CNT_W'(ID_LEN - 1)) cnt <= cnt + 1'b1;
            end else if (state == ST_PP) begin
                if (cnt < CNT_W'(PP_LIMIT)) cnt <= cnt + 1'b1;
            end
        end
    end

    a_r4_id_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ID) |-> (cnt < CNT_W'(ID_LEN)));
    a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(PP_LIMIT));
    a_r9_ce_clears_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (cnt == '0));
    a_r7_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_stb && !addr_stb) |=> $stable(state));
    a_r8_status_dropped_in_id: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ID && cmd_stb && io_in == OP_STATUS) |=> (state == ST_ID));
endmodule

// File: rtl/nand_idpp_rom.sv
// Byte source: supplies the byte for the current mode and counter position.
// The parameter page is a computed constant table; its index wraps every
// PAGE_BYTES (assumed a power of two), and past the copies the filler is given.
// The integrity CRC is a supplied constant, not computed here.
module nand_idpp_rom
    import nand_idpp_pkg::*;
#(
    parameter int          PAGE_BYTES = 256,
    parameter int          PP_COPIES  = 3,
    parameter logic [7:0]  FILL_BYTE  = 8'hFF,
    parameter logic [15:0] PP_CRC     = 16'h4C3A,
    localparam int PP_LIMIT = PAGE_BYTES * PP_COPIES,
    localparam int CNT_W    = $clog2(PP_LIMIT + 1),
    localparam int PG_W     = $clog2(PAGE_BYTES)
) (
    input  rd_state_e        state,
    input  logic [CNT_W-1:0] cnt,
    input  logic             single_ce_cfg,
    input  logic [7:0]       status_in,
    output logic [7:0]       byte_o
);
    localparam logic [95:0]  MFR_TXT   = "NAND VENDOR ";
    localparam logic [159:0] MODEL_TXT = "GENERIC-8G-X8       ";

    // Parameter page content for one in-page index.
    function automatic logic [7:0] pp_byte(input logic [PG_W-1:0] i);
        logic [7:0] b;
        int         n;
        n = int'(i);
        b = 8'h00;
        if (n >= 32 && n <= 43)      b = MFR_TXT[8*(43-n) +: 8];
        else if (n >= 44 && n <= 63) b = MODEL_TXT[8*(63-n) +: 8];
        else begin
            case (n)
                0:   b = 8'h4F;  1:   b = 8'h4E;  2:   b = 8'h46;  3:   b = 8'h49;
                4:   b = 8'h02;  6:   b = 8'h1E;  8:   b = 8'h1B;  64:  b = 8'h01;
                81:  b = 8'h08;  84:  b = 8'h40;  87:  b = 8'h02;  90:  b = 8'h10;
                92:  b = 8'h40;  97:  b = 8'h10;  100: b = 8'h02;  101: b = 8'h23;
                102: b = 8'h01;  103: b = 8'h50;  105: b = 8'h01;  106: b = 8'h05;
                107: b = 8'h01;  108: b = 8'h01;  109: b = 8'h03;  110: b = 8'h04;
                112: b = 8'h01;  113: b = 8'h01;  114: b = 8'h04;  128: b = 8'h0A;
                129: b = 8'h1F;  131: b = 8'h1F;  133: b = 8'hBC;  134: b = 8'h02;
                135: b = 8'h10;  136: b = 8'h27;  137: b = 8'h19;  139: b = 8'h64;
                254: b = PP_CRC[7:0];
                255: b = PP_CRC[15:8];
                default: b = 8'h00;
            endcase
        end
        return b;
    endfunction

    // Select the byte for the active mode.
    always_comb begin
        case (state)
            ST_ID:   byte_o = id_byte(single_ce_cfg, cnt[2:0]);
            ST_PP:   byte_o = (cnt >= CNT_W'(PP_LIMIT)) ? FILL_BYTE : pp_byte(cnt[PG_W-1:0]);
            ST_STAT: byte_o = status_in;
            default: byte_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/nand_idpp_responder.sv
// Top: the identification / parameter-page responder. It decodes the host's
// cycles, tracks the read-out mode and registers one byte onto io_out per
// falling read strobe. Assumes synchronised, slow pins.
module nand_idpp_responder
    import nand_idpp_pkg::*;
#(
    parameter int          PAGE_BYTES = 256,
    parameter int          PP_COPIES  = 3,
    parameter logic [7:0]  FILL_BYTE  = 8'hFF,
    parameter logic [15:0] PP_CRC     = 16'h4C3A,
    localparam int PP_LIMIT = PAGE_BYTES * PP_COPIES,
    localparam int CNT_W    = $clog2(PP_LIMIT + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic [7:0] io_in,
    input  logic       single_ce_cfg,
    input  logic [7:0] status_in,
    output logic [7:0] io_out,
    output logic [1:0] rd_mode
);
    logic             cmd_stb, addr_stb, re_fall;
    rd_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       src_byte;
    rd_mode_e         mode;

    nand_cycle_decode u_dec (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n),
        .cmd_stb(cmd_stb), .addr_stb(addr_stb), .re_fall(re_fall)
    );

    nand_rd_mode_ctrl #(.PAGE_BYTES(PAGE_BYTES), .PP_COPIES(PP_COPIES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cmd_stb(cmd_stb),
        .addr_stb(addr_stb), .re_fall(re_fall), .io_in(io_in),
        .state(state), .cnt(cnt)
    );

    nand_idpp_rom #(.PAGE_BYTES(PAGE_BYTES), .PP_COPIES(PP_COPIES),
                    .FILL_BYTE(FILL_BYTE), .PP_CRC(PP_CRC)) u_rom (
        .state(state), .cnt(cnt), .single_ce_cfg(single_ce_cfg),
        .status_in(status_in), .byte_o(src_byte)
    );

    // Map the internal state to the visible mode code.
    always_comb begin
        case (state)
            ST_ID:   mode = RM_ID;
            ST_PP:   mode = RM_PARAM;
            ST_STAT: mode = RM_STATUS;
            default: mode = RM_NONE;
        endcase
    end
    assign rd_mode = mode;

    // Register the selected byte on each read strobe in a read-out mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                         io_out <= 8'h00;
        else if (re_fall && mode != RM_NONE) io_out <= src_byte;
    end

    a_r11_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !re_fall |=> $stable(io_out));
    a_r6_filler_past_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PP && re_fall && cnt == CNT_W'(PP_LIMIT)) |=> (io_out == FILL_BYTE));
    a_r10_deselect_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> ($stable(io_out) && $stable(rd_mode)));
endmodule

// File: tb/nand_idpp_responder_tb_top.sv
// Directed bench for the identification / parameter-page responder.
module nand_idpp_responder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic       single_ce_cfg = 1'b0;
    logic [7:0] status_in = 8'h00;
    logic [7:0] io_out;
    logic [1:0] rd_mode;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    nand_idpp_responder dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .io_in(io_in), .single_ce_cfg(single_ce_cfg),
        .status_in(status_in), .io_out(io_out), .rd_mode(rd_mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_cycle(input logic is_cmd, input logic [7:0] b);
        @(negedge clk);
        cle = is_cmd; ale = ~is_cmd; io_in = b; we_n = 1'b0;
        wait_clk(2);
        we_n = 1'b1;
        wait_clk(2);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] b);
        @(negedge clk);
        re_n = 1'b0;
        wait_clk(2);
        b = io_out;
        re_n = 1'b1;
        wait_clk(2);
    endtask

    task automatic test_reset();
        chk("R1 mode", rd_mode, 0);
        chk("R1 io_out", io_out, 8'h00);
    endtask

    task automatic test_id(input logic single);
        logic [7:0] exp [5];
        logic [7:0] b;
        exp = single ? '{8'h01, 8'hD3, 8'hD1, 8'h95, 8'h58}
                     : '{8'h01, 8'hDC, 8'h90, 8'h95, 8'h54};
        single_ce_cfg = single;
        wr_cycle(1'b1, 8'h90);
        wr_cycle(1'b0, 8'h00);
        chk(single ? "R3 mode" : "R2 mode", rd_mode, 1);
        for (int i = 0; i < 5; i++) begin
            rd_byte(b);
            chk(single ? "R3 id byte" : "R2 id byte", b, exp[i]);
        end
        for (int i = 0; i < 2; i++) begin
            rd_byte(b);
            chk("R4 saturated id byte", b, exp[4]);
        end
    endtask

    task automatic test_status();
        logic [7:0] b;
        single_ce_cfg = 1'b0;
        wr_cycle(1'b1, 8'h90);
        wr_cycle(1'b0, 8'h00);
        rd_byte(b);
        rd_byte(b);
        wr_cycle(1'b1, 8'h70);
        chk("R8 status ignored in id", rd_mode, 1);
        rd_byte(b);
        chk("R8 id sequence continues", b, 8'h90);
        wr_cycle(1'b1, 8'h00);
        chk("R7 dummy leaves mode", rd_mode, 0);
        wr_cycle(1'b1, 8'h70);
        chk("R8 status mode", rd_mode, 3);
        status_in = 8'hA5;
        rd_byte(b);
        chk("R8 status byte", b, 8'hA5);
        status_in = 8'hC3;
        rd_byte(b);
        chk("R8 status byte follows input", b, 8'hC3);
    endtask

    task automatic test_param();
        logic [7:0] pg [771];
        wr_cycle(1'b1, 8'hEC);
        wr_cycle(1'b0, 8'h00);
        chk("R5 mode", rd_mode, 2);
        for (int i = 0; i < 771; i++) rd_byte(pg[i]);
        chk("R5 sig0", pg[0], 8'h4F);
        chk("R5 sig1", pg[1], 8'h4E);
        chk("R5 sig2", pg[2], 8'h46);
        chk("R5 sig3", pg[3], 8'h49);
        chk("R5 byte64", pg[64], 8'h01);
        chk("R5 byte100", pg[100], 8'h02);
        chk("R5 byte101", pg[101], 8'h23);
        for (int k = 0; k < 256; k++) begin
            chk("R6 copy2", pg[k + 256], pg[k]);
            chk("R6 copy3", pg[k + 512], pg[k]);
        end
        for (int k = 768; k < 771; k++) chk("R6 filler", pg[k], 8'hFF);
    endtask

    task automatic test_persist();
        logic [7:0] b;
        wr_cycle(1'b1, 8'hEC);
        wr_cycle(1'b0, 8'h00);
        rd_byte(b);
        rd_byte(b);
        rd_byte(b);
        wr_cycle(1'b0, 8'h5A);
        chk("R7 address keeps mode", rd_mode, 2);
        rd_byte(b);
        chk("R7 counter kept", b, 8'h49);
        wr_cycle(1'b1, 8'hFF);
        chk("R7 other command leaves", rd_mode, 0);
    endtask

    task automatic test_ce();
        logic [7:0] b;
        logic [7:0] held;
        single_ce_cfg = 1'b0;
        wr_cycle(1'b1, 8'h90);
        wr_cycle(1'b0, 8'h00);
        rd_byte(b);
        rd_byte(b);
        rd_byte(b);
        held = io_out;
        ce_n = 1'b1;
        wr_cycle(1'b1, 8'hFF);
        rd_byte(b);
        chk("R10 deselected command ignored", rd_mode, 1);
        chk("R10 deselected read ignored", io_out, held);
        ce_n = 1'b0;
        wait_clk(1);
        chk("R9 mode kept", rd_mode, 1);
        rd_byte(b);
        chk("R9 counter restarted", b, 8'h01);
        wr_cycle(1'b1, 8'h90);
        wr_cycle(1'b0, 8'h01);
        chk("R10 bad address", rd_mode, 0);
    endtask

    task automatic test_hold();
        logic [7:0] held;
        held = io_out;
        wr_cycle(1'b1, 8'hEC);
        wr_cycle(1'b0, 8'h00);
        wait_clk(5);
        chk("R11 io_out held", io_out, held);
    endtask

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(1);
        test_reset();
        test_id(1'b0);
        test_id(1'b1);
        test_status();
        test_param();
        test_persist();
        test_ce();
        test_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule